// File: doc/BRIEF.md
# Multiplexed ADC Monitor with Limit Trip

This block scans thirty-two analog monitor points (regulator voltages, regulator currents and board temperatures) through four 8-to-1 analog multiplexers. The multiplexers share one 3-bit select bus and one ADC input, so the block drives exactly one multiplexer enable at a time. It makes the ADC conversion clock by dividing the system clock by a programmable ratio. A conversion result reaches the block five conversions after the analog input was sampled, so the block tags each result with the channel that was selected at that earlier time.

The block visits each channel for a programmable number of settling conversions plus one. It keeps only the last result, writes it to a per-channel sample store, and compares it against that channel's lower and upper limits. A result outside the limits sets a sticky status bit. Each group of eight status bits drives one regulator inhibit output. Status and inhibit are held in three copies that are resolved by 2-of-3 vote, and every copy is rewritten with the voted value on every clock. A flat register port lets software read samples, read and write limits, and clear status bits.

Top module: `adc_scan_monitor`

## Requirements
- R1: `adc_clk` has a period of `div_ratio` system cycles and is high for `div_ratio/2` (rounded down) of them. A ratio of 0 or 1 behaves as 2.
- R2: Exactly one bit of `mux_en` is high at all times. Channel number c is read through multiplexer `c/8` (so `mux_en[c/8]` is high) with `mux_sel = c%8`.
- R3: Channels are visited in ascending order 0 to 31 and then wrap to 0. Each channel is held for `settle_cnt+1` rising edges of `adc_clk`. Select and enable change only on a system edge where `adc_clk` falls, and never on one where it rises.
- R4: The value on `adc_data` that the block captures at the system edge where `adc_clk` rises for conversion n is attributed to the channel that was selected at conversion n-5.
- R5: After each channel change, the first `settle_cnt` conversions are discarded. Only the next conversion is stored and compared. With `settle_cnt = 0` the first conversion is used.
- R6: A read with `reg_addr[6:5] = 0` returns the latest accepted sample of channel `reg_addr[4:0]` in bits 9:0. Writes to this region have no effect.
- R7: Region 1 holds the lower limit and region 2 the upper limit (bits 9:0, indexed by `reg_addr[4:0]`). After reset the lower limit is 0 and the upper limit is 1023. A sample violates only if it is strictly below the lower limit or strictly above the upper limit.
- R8: A violation sets status bit c, which is read in region 3 as a 32-bit word. The bit stays set until software writes a 1 to it in region 3, and it is clear at the edge that follows that write. A violation that is still present sets the bit again at the next scan. A violation and a clear in the same cycle leave the bit set.
- R9: `inhibit[g]` is the OR of status bits 8g to 8g+7 and is updated on the same edge as the status bits.
- R10: During reset, `mux_en = 4'b0001`, `mux_sel = 0`, `adc_clk = 0`, `inhibit = 0` and the status word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_ratio | input | 8 | System cycles per ADC conversion |
| settle_cnt | input | 4 | Conversions discarded after each channel change |
| adc_clk | output | 1 | Conversion clock to the ADC |
| adc_data | input | 10 | ADC result, five conversions delayed |
| mux_sel | output | 3 | Select shared by all multiplexers |
| mux_en | output | 4 | One-hot multiplexer enables |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Region in bits 6:5, channel in bits 4:0 |
| reg_wdata | input | 32 | Write data (region 3: write 1 to clear) |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| inhibit | output | 4 | Regulator inhibit, one per multiplexer group |

## Verification
A register read is valid in the same cycle, so the bench changes `reg_addr` on a falling edge and samples 1 ns later. A status clear takes effect at the next rising edge and is sampled at the falling edge after it. A violation shows up in status and `inhibit` on the same edge where the matching sample is captured, which is five conversions after the channel was sampled. Because that can fall anywhere in a scan, the bench waits more than two full scans (32 × 3 × 4 cycles each) before it reads results. The ADC clock period, the channel order, the dwell length and the timing of select changes are measured cycle by cycle at falling system edges.

// File: rtl/adc_mon_pkg.sv
// Shared sizes and register regions for the ADC scan monitor.
package adc_mon_pkg;
    parameter int NUM_MUX    = 4;
    parameter int MUX_WAYS   = 8;
    parameter int SAMPLE_W   = 10;
    parameter int PIPE_DEPTH = 5;
    parameter int DIV_W      = 8;
    parameter int SETTLE_W   = 4;
    parameter int DATA_W     = 32;
    localparam int NUM_CH    = NUM_MUX * MUX_WAYS;
    localparam int SEL_W     = $clog2(MUX_WAYS);
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int GRP_W     = CH_W - SEL_W;
    localparam int ADDR_W    = CH_W + 2;

    typedef enum logic [1:0] {
        RGN_SAMPLE = 2'd0,
        RGN_LOW    = 2'd1,
        RGN_HIGH   = 2'd2,
        RGN_STATUS = 2'd3
    } region_e;
endpackage

// File: rtl/adc_clk_div.sv
// Divides the system clock into the ADC conversion clock.
// Assumes div_ratio values below 2 mean 2. cap_stb marks the system edge on
// which adc_clk rises; adv_stb marks the edge on which it falls.
module adc_clk_div
    import adc_mon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_ratio_i,
    output logic             adc_clk_o,
    output logic             cap_stb_o,
    output logic             adv_stb_o
);
    logic [DIV_W-1:0] cnt_q, cnt_nxt, div_eff, half;

    // next count value, wrapping at the effective ratio
    always_comb begin
        div_eff = (div_ratio_i < DIV_W'(2)) ? DIV_W'(2) : div_ratio_i;
        half    = div_eff >> 1;
        cnt_nxt = (cnt_q >= div_eff - DIV_W'(1)) ? '0 : cnt_q + DIV_W'(1);
    end

    assign cap_stb_o = (cnt_nxt == '0);
    assign adv_stb_o = (cnt_nxt == half);

    // counter and registered clock output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '1;
            adc_clk_o <= 1'b0;
        end else begin
            cnt_q     <= cnt_nxt;
            adc_clk_o <= (cnt_nxt < half);
        end
    end

    assert_clk_rise_on_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_clk_o) |-> $past(cap_stb_o));
endmodule

// File: rtl/adc_scan_seq.sv
// Walks the channels, drives the shared select and the one-hot enables, and
// tracks which channel each delayed ADC result belongs to.
// Assumes cap_stb and adv_stb never fire on the same cycle.
module adc_scan_seq
    import adc_mon_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_stb_i,
    input  logic                adv_stb_i,
    input  logic [SETTLE_W-1:0] settle_i,
    output logic [SEL_W-1:0]    mux_sel_o,
    output logic [NUM_MUX-1:0]  mux_en_o,
    output logic                tag_valid_o,
    output logic [CH_W-1:0]     tag_ch_o
);
    logic [CH_W-1:0]                  ch_q;
    logic [SETTLE_W-1:0]              dwell_q;
    logic                             pend_q;
    logic [PIPE_DEPTH-1:0][CH_W-1:0]  hist_ch_q;
    logic [PIPE_DEPTH-1:0]            hist_v_q;
    logic                             settled;

    assign settled = (dwell_q >= settle_i);

    // channel stepping and history of sampled channels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q      <= '0;
            dwell_q   <= '0;
            pend_q    <= 1'b0;
            hist_ch_q <= '0;
            hist_v_q  <= '0;
        end else if (cap_stb_i) begin
            hist_ch_q <= {hist_ch_q[PIPE_DEPTH-2:0], ch_q};
            hist_v_q  <= {hist_v_q[PIPE_DEPTH-2:0], settled};
            if (settled) pend_q  <= 1'b1;
            else         dwell_q <= dwell_q + SETTLE_W'(1);
        end else if (adv_stb_i && pend_q) begin
            ch_q    <= ch_q + CH_W'(1);
            dwell_q <= '0;
            pend_q  <= 1'b0;
        end
    end

    assign tag_valid_o = cap_stb_i & hist_v_q[PIPE_DEPTH-1];
    assign tag_ch_o    = hist_ch_q[PIPE_DEPTH-1];
    assign mux_sel_o   = ch_q[SEL_W-1:0];

    for (genvar g = 0; g < NUM_MUX; g++) begin : g_en
        assign mux_en_o[g] = (ch_q[CH_W-1:SEL_W] == GRP_W'(g));
    end

    assert_one_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mux_en_o) == 1);
    assert_select_still_on_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb_i |=> $stable({mux_sel_o, mux_en_o}));
endmodule

// File: rtl/adc_sample_store.sv
// Holds samples and per-channel limits, checks accepted samples, and serves
// register reads for the sample and limit regions.
module adc_sample_store
    import adc_mon_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tag_valid_i,
    input  logic [CH_W-1:0]     tag_ch_i,
    input  logic [SAMPLE_W-1:0] adc_data_i,
    input  logic                reg_we_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [NUM_CH-1:0]   viol_set_o,
    output logic [DATA_W-1:0]   rd_data_o
);
    logic [SAMPLE_W-1:0] smp_q [NUM_CH];
    logic [SAMPLE_W-1:0] lo_q  [NUM_CH];
    logic [SAMPLE_W-1:0] hi_q  [NUM_CH];
    region_e             rgn;
    logic [CH_W-1:0]     idx;
    logic                out_of_range;

    assign rgn = region_e'(reg_addr_i[ADDR_W-1:CH_W]);
    assign idx = reg_addr_i[CH_W-1:0];

    // limit check of the tagged sample
    always_comb begin
        out_of_range = (adc_data_i < lo_q[tag_ch_i]) || (adc_data_i > hi_q[tag_ch_i]);
        viol_set_o   = '0;
        if (tag_valid_i && out_of_range) viol_set_o[tag_ch_i] = 1'b1;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // per-channel sample and limit registers
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                smp_q[c] <= '0;
                lo_q[c]  <= '0;
                hi_q[c]  <= '1;
            end else begin
                if (tag_valid_i && tag_ch_i == CH_W'(c)) smp_q[c] <= adc_data_i;
                if (reg_we_i && idx == CH_W'(c) && rgn == RGN_LOW)  lo_q[c] <= reg_wdata_i[SAMPLE_W-1:0];
                if (reg_we_i && idx == CH_W'(c) && rgn == RGN_HIGH) hi_q[c] <= reg_wdata_i[SAMPLE_W-1:0];
            end
        end
    end

    // read data for the non-status regions
    always_comb begin
        case (rgn)
            RGN_SAMPLE: rd_data_o = DATA_W'(smp_q[idx]);
            RGN_LOW:    rd_data_o = DATA_W'(lo_q[idx]);
            RGN_HIGH:   rd_data_o = DATA_W'(hi_q[idx]);
            default:    rd_data_o = '0;
        endcase
    end

    assert_sample_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid_i |=> (smp_q[$past(tag_ch_i)] == $past(adc_data_i)));
endmodule

// File: rtl/adc_tmr_status.sv
// Sticky status bits and group inhibits, each kept in three copies resolved
// by 2-of-3 vote; every copy takes the voted next value on each clock.
module adc_tmr_status
    import adc_mon_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CH-1:0]  set_i,
    input  logic [NUM_CH-1:0]  clr_i,
    output logic [NUM_CH-1:0]  status_o,
    output logic [NUM_MUX-1:0] inhibit_o
);
    logic [NUM_CH-1:0]  st_nxt;
    logic [NUM_MUX-1:0] inh_nxt, stat_grp;

    for (genvar k = 0; k < 3; k++) begin : g_copy
        logic [NUM_CH-1:0]  st_q;
        logic [NUM_MUX-1:0] inh_q;
        // copy k, rewritten each clock (scrub)
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= '0;
                inh_q <= '0;
            end else begin
                st_q  <= st_nxt;
                inh_q <= inh_nxt;
            end
        end
    end

    assign status_o = (g_copy[0].st_q & g_copy[1].st_q) | (g_copy[0].st_q & g_copy[2].st_q)
                    | (g_copy[1].st_q & g_copy[2].st_q);
    assign inhibit_o = (g_copy[0].inh_q & g_copy[1].inh_q) | (g_copy[0].inh_q & g_copy[2].inh_q)
                     | (g_copy[1].inh_q & g_copy[2].inh_q);
    assign st_nxt = (status_o & ~clr_i) | set_i;

    for (genvar g = 0; g < NUM_MUX; g++) begin : g_grp
        assign inh_nxt[g]  = |st_nxt[g*MUX_WAYS +: MUX_WAYS];
        assign stat_grp[g] = |status_o[g*MUX_WAYS +: MUX_WAYS];
    end

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((status_o & $past(status_o)) == $past(status_o)));
    assert_set_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));
    assert_clear_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((status_o & $past(clr_i & ~set_i)) == '0));
    assert_inhibit_tracks_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_o == stat_grp);
endmodule

// File: rtl/adc_scan_monitor.sv
// Top of the ADC scan monitor: clock divider, channel sequencer, sample and
// limit store, and voted status. Region 3 of the register port reads status
// and clears bits written as 1. Assumes NUM_CH <= DATA_W.
module adc_scan_monitor
    import adc_mon_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    div_ratio,
    input  logic [SETTLE_W-1:0] settle_cnt,
    output logic                adc_clk,
    input  logic [SAMPLE_W-1:0] adc_data,
    output logic [SEL_W-1:0]    mux_sel,
    output logic [NUM_MUX-1:0]  mux_en,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NUM_MUX-1:0]  inhibit
);
    logic                cap_stb, adv_stb, tag_valid;
    logic [CH_W-1:0]     tag_ch;
    logic [NUM_CH-1:0]   viol_set, clr_mask, status;
    logic [DATA_W-1:0]   store_rd;
    logic                status_sel;

    adc_clk_div u_div (
        .clk(clk), .rst_n(rst_n), .div_ratio_i(div_ratio),
        .adc_clk_o(adc_clk), .cap_stb_o(cap_stb), .adv_stb_o(adv_stb)
    );

    adc_scan_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cap_stb_i(cap_stb), .adv_stb_i(adv_stb),
        .settle_i(settle_cnt), .mux_sel_o(mux_sel), .mux_en_o(mux_en),
        .tag_valid_o(tag_valid), .tag_ch_o(tag_ch)
    );

    adc_sample_store u_store (
        .clk(clk), .rst_n(rst_n), .tag_valid_i(tag_valid), .tag_ch_i(tag_ch),
        .adc_data_i(adc_data), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .viol_set_o(viol_set), .rd_data_o(store_rd)
    );

    adc_tmr_status u_stat (
        .clk(clk), .rst_n(rst_n), .set_i(viol_set), .clr_i(clr_mask),
        .status_o(status), .inhibit_o(inhibit)
    );

    // status region decode: write-one-to-clear and read select
    assign status_sel = (region_e'(reg_addr[ADDR_W-1:CH_W]) == RGN_STATUS);
    assign clr_mask   = (reg_we && status_sel) ? reg_wdata[NUM_CH-1:0] : '0;
    assign reg_rdata  = status_sel ? DATA_W'(status) : store_rd;
endmodule

// File: tb/adc_scan_monitor_tb_top.sv
module adc_scan_monitor_tb_top;
    localparam int DIV = 4;
    localparam int SET = 2;
    localparam int NT  = 8;
    // {channel, analog value, low limit, high limit, expected trip}
    localparam logic [35:0] TBL [NT] = '{
        {5'd0,  10'd500,  10'd20,  10'd900,  1'b0},
        {5'd3,  10'd100,  10'd50,  10'd200,  1'b0},
        {5'd5,  10'd300,  10'd300, 10'd400,  1'b0},
        {5'd9,  10'd400,  10'd100, 10'd400,  1'b0},
        {5'd12, 10'd99,   10'd100, 10'd500,  1'b1},
        {5'd18, 10'd701,  10'd100, 10'd700,  1'b1},
        {5'd26, 10'd555,  10'd500, 10'd600,  1'b0},
        {5'd31, 10'd1023, 10'd10,  10'd1000, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, adc_clk;
    logic [7:0] div_ratio = 8'(DIV);
    logic [3:0] settle_cnt = 4'(SET);
    logic [9:0] adc_data = '0;
    logic [2:0] mux_sel;
    logic [3:0] mux_en, inhibit;
    logic [6:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    adc_scan_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .settle_cnt(settle_cnt),
        .adc_clk(adc_clk), .adc_data(adc_data), .mux_sel(mux_sel), .mux_en(mux_en),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .inhibit(inhibit)
    );

    // analog sources and ADC model: garbage for the first SET conversions
    // after a select change, five-conversion result delay
    logic [9:0] ana [32];
    logic [9:0] pipe [5];
    int since = 0, last_ch = 0, cur;
    logic [9:0] v;

    function automatic int port_ch();
        int r = -1;
        if ($countones(mux_en) == 1)
            for (int g = 0; g < 4; g++) if (mux_en[g]) r = g * 8 + int'(mux_sel);
        return r;
    endfunction

    always @(posedge adc_clk) begin
        cur = port_ch();
        if (cur != last_ch) since = 0;
        v = (cur < 0 || since < SET) ? 10'd0 : ana[cur];
        since++;
        last_ch = cur;
        for (int i = 4; i > 0; i--) pipe[i] = pipe[i-1];
        pipe[0] = v;
        adc_data = pipe[4];
    end

    // scan monitor for R2/R3
    int mon_err = 0, rises = 0, prev_ch = 0, mch;
    logic prev_adc = 1'b0;
    bit mon_en = 1'b0, seen = 1'b0;
    always @(negedge clk) if (rst_n) begin
        mch = port_ch();
        if (mch < 0) mon_err++;
        if (adc_clk && !prev_adc) begin
            if (mon_en && mch != prev_ch) mon_err++;
            rises++;
        end
        if (mch != prev_ch) begin
            if (mon_en && seen && (rises != SET + 1 || mch != (prev_ch + 1) % 32)) mon_err++;
            seen = mon_en;
            rises = 0;
        end
        prev_ch = mch;
        prev_adc = adc_clk;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_read(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic reg_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic measure(output int per, output int hi);
        logic p;
        p = adc_clk;
        forever begin @(negedge clk); if (adc_clk && !p) break; p = adc_clk; end
        per = 0; hi = 0; p = 1'b1;
        forever begin
            per++;
            if (adc_clk) hi++;
            @(negedge clk);
            if (adc_clk && !p) break;
            p = adc_clk;
        end
    endtask

    task automatic check_div(input int r, input int eper, input int ehi);
        int per, hi;
        div_ratio = 8'(r);
        repeat (20) @(negedge clk);
        measure(per, hi);
        measure(per, hi);
        chk(per == eper, "R1 period", per, eper);
        chk(hi == ehi, "R1 high time", hi, ehi);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int c = 0; c < 32; c++) ana[c] = 10'(c * 20 + 40);
        for (int i = 0; i < 5; i++) pipe[i] = '0;
        repeat (4) @(negedge clk);
        // R10 reset state
        chk(mux_en == 4'b0001, "R10 mux_en", mux_en, 1);
        chk(mux_sel == 3'd0, "R10 mux_sel", mux_sel, 0);
        chk(adc_clk == 1'b0, "R10 adc_clk", adc_clk, 0);
        chk(inhibit == 4'd0, "R10 inhibit", inhibit, 0);
        reg_read({2'd3, 5'd0}, d);
        chk(d == 32'd0, "R10 status", d, 0);
        reg_read({2'd1, 5'd7}, d);
        chk(d == 32'd0, "R7 low limit reset", d, 0);
        reg_read({2'd2, 5'd7}, d);
        chk(d == 32'd1023, "R7 high limit reset", d, 1023);
        @(negedge clk) rst_n = 1'b1;

        // R1 divider ratios, including the clamp below 2
        check_div(4, 4, 2);
        check_div(1, 2, 1);
        check_div(5, 5, 2);
        check_div(DIV, DIV, DIV / 2);

        // table walk: program limits and sources, then check every entry
        mon_en = 1'b1;
        for (int i = 0; i < NT; i++) begin
            ana[TBL[i][35:31]] = TBL[i][30:21];
            reg_write({2'd1, TBL[i][35:31]}, 32'(TBL[i][20:11]));
            reg_write({2'd2, TBL[i][35:31]}, 32'(TBL[i][10:1]));
        end
        repeat (1200) @(negedge clk);
        for (int i = 0; i < NT; i++) begin
            reg_read({2'd0, TBL[i][35:31]}, d);
            chk(d == 32'(TBL[i][30:21]), "R4 R5 sample of table channel", d, TBL[i][30:21]);
            reg_read({2'd3, 5'd0}, d);
            chk(d[TBL[i][35:31]] == TBL[i][0], "R7 R8 status of table channel",
                d[TBL[i][35:31]], TBL[i][0]);
        end
        for (int c = 0; c < 32; c++) begin
            reg_read({2'd0, 5'(c)}, d);
            chk(d == 32'(ana[c]), "R4 R2 sample per channel", d, ana[c]);
        end
        chk(mon_err == 0, "R2 R3 scan order, dwell and select timing", mon_err, 0);
        mon_en = 1'b0;
        @(negedge clk);
        chk(inhibit == 4'b1110, "R9 inhibit groups", inhibit, 4'b1110);

        // R6 writes to the sample region are ignored
        reg_write({2'd0, 5'd3}, 32'd0);
        reg_read({2'd0, 5'd3}, d);
        chk(d == 32'd100, "R6 sample write ignored", d, 100);

        // R8 sticky after the source returns in range, then clear
        ana[12] = 10'd300;
        repeat (1200) @(negedge clk);
        reg_read({2'd3, 5'd0}, d);
        chk(d[12] == 1'b1, "R8 sticky status", d[12], 1);
        reg_write({2'd3, 5'd0}, 32'h1 << 12);
        reg_read({2'd3, 5'd0}, d);
        chk(d[12] == 1'b0, "R8 clear", d[12], 0);
        chk(inhibit == 4'b1100, "R9 inhibit after clear", inhibit, 4'b1100);

        // R8 clear while the violation persists: re-trips on next scan
        reg_write({2'd3, 5'd0}, 32'h1 << 18);
        reg_read({2'd3, 5'd0}, d);
        chk(d[18] == 1'b0, "R8 clear of live violation", d[18], 0);
        chk(inhibit == 4'b1000, "R9 inhibit after second clear", inhibit, 4'b1000);
        repeat (1200) @(negedge clk);
        reg_read({2'd3, 5'd0}, d);
        chk(d[18] == 1'b1, "R8 re-trip", d[18], 1);
        chk(inhibit == 4'b1100, "R9 inhibit after re-trip", inhibit, 4'b1100);

        // R5 with no settling the first (garbage) conversion is accepted
        settle_cnt = 4'd0;
        repeat (1200) @(negedge clk);
        reg_read({2'd3, 5'd0}, d);
        chk(d[0] == 1'b1, "R5 zero settle accepts first conversion", d[0], 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule